// File: doc/BRIEF.md
# Serial Baseband Output Port

This block sends filtered I/Q result pairs out over a synchronous serial link that a DSP serial receiver can accept directly. Each result pair is captured into a holding store when `sample_valid_i` pulses. The block sends it as one frame: the I word, then the Q word, and optionally a third word that carries a status byte. Every word goes out most significant bit first. The frame length per word is chosen from four lengths. The word length and the append option are frozen when a frame starts.

The port works in one of two clock roles. As bus master, it divides the system clock by a programmable 4-bit value to make the serial clock. It also drives a one-period frame-sync pulse with the first bit of each frame. As a cascaded unit, it follows a serial clock and a frame-start strobe from outside. Both are resynchronised into the system clock domain. One serial period after the last bit, the port raises a frame-end strobe for one serial period. Several units can therefore be chained: each unit's frame-end drives the frame-start input of the next unit. Its serial data line is enabled only during its own frame bits, so the chained units can share one wire.

Top module: `bb_serial_tx`

## Requirements
- R1: In master role, the serial clock period is 2 × (div_i + 1) system clocks. In cascade role, `sclk_o` stays low.
- R2: In master role, `fs_o` is high for exactly one serial clock period, and that period is the one that carries the first bit of the frame. In cascade role, `fs_o` stays low.
- R3: Each word is sent MSB first and is the top L bits of a 24-bit field. L is 12, 16, 20 or 24 for `wl_sel_i` codes 0, 1, 2 and 3. The I word is sent first, then the Q word.
- R4: When `append_i` is 1, a third word follows the Q word. Its 24-bit field holds `status_i` in bits 23:16 and zeros in bits 15:0, and it is cut to L bits like the other words.
- R5: At the serial clock rising edge after the last bit, `sfe_o` goes high for exactly one serial period, and `sdo_oe_o` goes low at that same edge.
- R6: `sdo_oe_o` is high exactly during the bit periods of the port's own frame. While it is low, `sdo_o` is 0.
- R7: `sdo_o` changes only where a serial clock rising edge has been recognised.
- R8: In master role, a frame starts at a serial rising edge only when a sample has been captured since the previous frame started. One sample gives exactly one frame.
- R9: In cascade role, a frame starts at the first external serial rising edge for which `fs_i` was high just before the edge. Each external clock level must last at least 4 system clocks. Outputs settle within 3 system clocks of an external rising edge.
- R10: The word length and the append setting are latched at frame start. If `wl_sel_i` or `append_i` changes during a frame, that frame is not affected.
- R11: While reset is asserted, `sclk_o`, `fs_o`, `sfe_o`, `sdo_o` and `sdo_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Captures the I, Q and status inputs |
| i_data_i | input | 24 | In-phase result, MSB aligned |
| q_data_i | input | 24 | Quadrature result, MSB aligned |
| status_i | input | 8 | Status byte for the appended word |
| master_i | input | 1 | 1 = port drives the serial clock and frame sync, 0 = cascade |
| div_i | input | 4 | Serial clock divide value (master role) |
| wl_sel_i | input | 2 | Word length code |
| append_i | input | 1 | Adds the status word to each frame |
| sclk_i | input | 1 | External serial clock (cascade role) |
| fs_i | input | 1 | External frame start (cascade role) |
| sclk_o | output | 1 | Generated serial clock |
| fs_o | output | 1 | Frame sync pulse (master role) |
| sfe_o | output | 1 | Frame-end pulse |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the shared data line |

## Verification
The assertions check on every cycle that:
- frame sync and frame end each last exactly one serial period;
- the data enable opens together with frame sync in master role and closes together with frame end;
- the generated clock rises only on a recognised edge, and stays low in cascade role;
- serial data moves only after a recognised rising edge.

Other behaviour can only be shown by the bench scenarios. These cover the divide ratio, the content and order of the bits for each word length and with the status word, the one-frame-per-sample rule, the latching of settings in mid-frame, and the start of a cascaded frame from an external strobe.

// File: rtl/bb_serial_pkg.sv
package bb_serial_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_TAIL  = 2'd2
  } frame_state_t;

  // Index of the word inside a frame: 0 = I, 1 = Q, 2 = status
  typedef logic [1:0] word_idx_t;

  localparam int WL_STEP = 4;

endpackage

// File: rtl/bb_serial_clkgen.sv
module bb_serial_clkgen #(
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_ext_i,
  input  logic             fs_ext_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fs_ext_o
);

  // Resynchronise the external clock and frame start
  logic [SYNC_N-1:0] sck_sync_q;
  logic [SYNC_N-1:0] fs_sync_q;
  logic              sck_prev_q;
  logic              fs_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync_q <= '0;
      fs_sync_q  <= '0;
      sck_prev_q <= 1'b0;
      fs_prev_q  <= 1'b0;
    end else begin
      sck_sync_q <= {sck_sync_q[SYNC_N-2:0], sclk_ext_i};
      fs_sync_q  <= {fs_sync_q[SYNC_N-2:0], fs_ext_i};
      sck_prev_q <= sck_sync_q[SYNC_N-1];
      fs_prev_q  <= fs_sync_q[SYNC_N-1];
    end
  end

  logic rise_ext;
  assign rise_ext = sck_sync_q[SYNC_N-1] & ~sck_prev_q;
  // Frame start value seen just before the recognised edge
  assign fs_ext_o = fs_prev_q;

  // Divider for the master role
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             hit;

  assign hit = (cnt_q == div_q);

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    div_d  = div_q;
    sclk_d = sclk_q;
    if (!master_i) begin
      cnt_d  = '0;
      div_d  = div_i;
      sclk_d = 1'b0;
    end else if (hit) begin
      cnt_d  = '0;
      div_d  = div_i;
      sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = master_i ? (hit & ~sclk_q) : rise_ext;

  AST_SCLK_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(rise_o)) else $error("sclk rose without edge flag"); // R1
  AST_SCLK_QUIET_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !$past(master_i)) |-> !sclk_o) else $error("sclk active in cascade"); // R1

endmodule

// File: rtl/bb_serial_framer.sv
module bb_serial_framer
  import bb_serial_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise_i,
  input  logic      master_i,
  input  logic      fs_ext_i,
  input  logic      sample_valid_i,
  input  logic [1:0] wl_i,
  input  logic      app_i,
  output logic      start_o,
  output logic      load_o,
  output logic      shift_o,
  output word_idx_t word_sel_o,
  output logic      fs_o,
  output logic      sfe_o,
  output logic      oe_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  frame_state_t st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] len_q, len_d;
  word_idx_t        word_q, word_d;
  word_idx_t        last_q, last_d;
  logic             fs_q, fs_d;
  logic             sfe_q, sfe_d;
  logic             oe_q, oe_d;
  logic             pend_q, pend_d;

  logic             start_c;
  logic [CNT_W-1:0] len_new;

  assign len_new = CNT_W'(DATA_W - WL_STEP * (3 - int'(wl_i)));
  assign start_c = rise_i && (st_q == FR_IDLE) && (master_i ? pend_q : fs_ext_i);

  always_comb begin
    st_d       = st_q;
    bit_d      = bit_q;
    len_d      = len_q;
    word_d     = word_q;
    last_d     = last_q;
    fs_d       = fs_q;
    sfe_d      = sfe_q;
    oe_d       = oe_q;
    pend_d     = pend_q | sample_valid_i;
    load_o     = 1'b0;
    shift_o    = 1'b0;
    word_sel_o = word_q + 2'd1;
    unique case (st_q)
      FR_IDLE: begin
        if (start_c) begin
          st_d       = FR_SHIFT;
          len_d      = len_new;
          bit_d      = len_new - 1'b1;
          word_d     = '0;
          last_d     = app_i ? 2'd2 : 2'd1;
          fs_d       = master_i;
          oe_d       = 1'b1;
          pend_d     = sample_valid_i;
          load_o     = 1'b1;
          word_sel_o = '0;
        end
      end
      FR_SHIFT: begin
        if (rise_i) begin
          fs_d = 1'b0;
          if (bit_q == '0) begin
            if (word_q == last_q) begin
              st_d  = FR_TAIL;
              sfe_d = 1'b1;
              oe_d  = 1'b0;
            end else begin
              word_d = word_q + 2'd1;
              bit_d  = len_q - 1'b1;
              load_o = 1'b1;
            end
          end else begin
            bit_d   = bit_q - 1'b1;
            shift_o = 1'b1;
          end
        end
      end
      default: begin
        if (rise_i) begin
          sfe_d = 1'b0;
          st_d  = FR_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      bit_q  <= '0;
      len_q  <= '0;
      word_q <= '0;
      last_q <= '0;
      fs_q   <= 1'b0;
      sfe_q  <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      len_q  <= len_d;
      word_q <= word_d;
      last_q <= last_d;
      fs_q   <= fs_d;
      sfe_q  <= sfe_d;
      oe_q   <= oe_d;
      pend_q <= pend_d;
    end
  end

  assign start_o = start_c;
  assign fs_o    = fs_q;
  assign sfe_o   = sfe_q;
  assign oe_o    = oe_q;

  AST_FS_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_o && rise_i) |=> !fs_o) else $error("frame sync too long"); // R2
  AST_SFE_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (sfe_o && rise_i) |=> !sfe_o) else $error("frame end too long"); // R5
  AST_OE_OPENS_WITH_FS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_o) && $past(master_i)) |-> fs_o) else $error("enable without sync"); // R6
  AST_OE_CLOSES_WITH_SFE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> sfe_o) else $error("enable closed without frame end"); // R5

endmodule

// File: rtl/bb_serial_shifter.sv
module bb_serial_shifter
  import bb_serial_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ST_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] i_i,
  input  logic [DATA_W-1:0] q_i,
  input  logic [ST_W-1:0]   st_i,
  input  logic              capture_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  word_idx_t         word_sel_i,
  output logic              bit_o
);

  localparam int PAD_W = DATA_W - ST_W;

  logic [DATA_W-1:0] i_h_q, q_h_q, i_f_q, q_f_q;
  logic [ST_W-1:0]   st_h_q, st_f_q;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] word_c;

  // Holding store, written by each captured sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_h_q  <= '0;
      q_h_q  <= '0;
      st_h_q <= '0;
    end else if (sample_valid_i) begin
      i_h_q  <= i_i;
      q_h_q  <= q_i;
      st_h_q <= st_i;
    end
  end

  // Frame copy, frozen for the length of one frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_f_q  <= '0;
      q_f_q  <= '0;
      st_f_q <= '0;
    end else if (capture_i) begin
      i_f_q  <= i_h_q;
      q_f_q  <= q_h_q;
      st_f_q <= st_h_q;
    end
  end

  always_comb begin
    unique case (word_sel_i)
      2'd0:    word_c = capture_i ? i_h_q : i_f_q;
      2'd1:    word_c = q_f_q;
      default: word_c = {st_f_q, {PAD_W{1'b0}}};
    endcase
  end

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = word_c;
    else if (shift_i) sh_d = {sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_o = sh_q[DATA_W-1];

endmodule

// File: rtl/bb_serial_tx.sv
module bb_serial_tx
  import bb_serial_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ST_W   = 8,
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] i_data_i,
  input  logic [DATA_W-1:0] q_data_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic              master_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        wl_sel_i,
  input  logic              append_i,
  input  logic              sclk_i,
  input  logic              fs_i,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sfe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  logic      rise_w, fs_ext_w;
  logic      start_w, load_w, shift_w, oe_w, bit_w;
  word_idx_t word_sel_w;

  bb_serial_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_i  (master_i),
    .div_i     (div_i),
    .sclk_ext_i(sclk_i),
    .fs_ext_i  (fs_i),
    .sclk_o    (sclk_o),
    .rise_o    (rise_w),
    .fs_ext_o  (fs_ext_w)
  );

  bb_serial_framer #(.DATA_W(DATA_W)) framer_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise_i        (rise_w),
    .master_i      (master_i),
    .fs_ext_i      (fs_ext_w),
    .sample_valid_i(sample_valid_i),
    .wl_i          (wl_sel_i),
    .app_i         (append_i),
    .start_o       (start_w),
    .load_o        (load_w),
    .shift_o       (shift_w),
    .word_sel_o    (word_sel_w),
    .fs_o          (fs_o),
    .sfe_o         (sfe_o),
    .oe_o          (oe_w)
  );

  bb_serial_shifter #(.DATA_W(DATA_W), .ST_W(ST_W)) shifter_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_valid_i(sample_valid_i),
    .i_i           (i_data_i),
    .q_i           (q_data_i),
    .st_i          (status_i),
    .capture_i     (start_w),
    .load_i        (load_w),
    .shift_i       (shift_w),
    .word_sel_i    (word_sel_w),
    .bit_o         (bit_w)
  );

  assign sdo_oe_o = oe_w;
  assign sdo_o    = bit_w & oe_w;

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && $changed(sdo_o)) |-> $past(rise_w))
    else $error("data moved off edge"); // R7
  AST_SDO_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o) else $error("data driven while disabled"); // R6

endmodule

// File: tb/bb_serial_tx_tb_top.sv
module bb_serial_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_valid_i;
  logic [23:0] i_data_i, q_data_i;
  logic [7:0]  status_i;
  logic        master_i;
  logic [3:0]  div_i;
  logic [1:0]  wl_sel_i;
  logic        append_i;
  logic        sclk_i, fs_i;
  logic        sclk_o, fs_o, sfe_o, sdo_o, sdo_oe_o;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bb_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .sample_valid_i(sample_valid_i),
    .i_data_i(i_data_i), .q_data_i(q_data_i), .status_i(status_i),
    .master_i(master_i), .div_i(div_i), .wl_sel_i(wl_sel_i), .append_i(append_i),
    .sclk_i(sclk_i), .fs_i(fs_i), .sclk_o(sclk_o), .fs_o(fs_o), .sfe_o(sfe_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wlen(input int code);
    return 12 + 4 * code;
  endfunction

  function automatic bit exp_bit(input int j, input int n, input logic [23:0] a,
                                 input logic [23:0] b, input logic [7:0] s);
    logic [23:0] w;
    int k;
    k = j / n;
    w = (k == 0) ? a : (k == 1) ? b : {s, 16'h0000};
    return w[23 - (j % n)];
  endfunction

  task automatic wait_rise(output int n);
    bit prev;
    n = 0;
    forever begin
      prev = sclk_o;
      @(negedge clk);
      n++;
      if (sclk_o && !prev) break;
      if (n > 4000) begin
        chk(1'b0, "R1", "serial clock timeout", n, 0);
        break;
      end
    end
  endtask

  task automatic run_master(input int div, input int wl, input bit app,
                            input logic [23:0] iv, input logic [23:0] qv,
                            input logic [7:0] sv, input bit chg);
    int per, n, tot, bad_j;
    bit found, bad, fs_bad, got, want;
    string req;
    master_i = 1'b1; div_i = 4'(div); wl_sel_i = 2'(wl); append_i = app;
    repeat (3) wait_rise(per);
    i_data_i = iv; q_data_i = qv; status_i = sv;
    sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
    found = 1'b0;
    for (int k = 0; k < 4 && !found; k++) begin
      wait_rise(per);
      if (fs_o) found = 1'b1;
    end
    chk(found, "R8", "frame start after sample", found, 1);
    if (!found) return;
    n = wlen(wl); tot = n * (app ? 3 : 2);
    bad = 1'b0; fs_bad = 1'b0; bad_j = 0; got = 0; want = 0;
    for (int j = 0; j < tot; j++) begin
      if (j > 0) begin
        wait_rise(per);
        if (j == 1) chk(per == 2 * (div + 1), "R1", "serial period", per, 2 * (div + 1));
      end
      if (!bad && (!sdo_oe_o || sdo_o !== exp_bit(j, n, iv, qv, sv))) begin
        bad = 1'b1; bad_j = j; got = sdo_o;
        want = exp_bit(j, n, iv, qv, sv);
      end
      if (fs_o != (j == 0)) fs_bad = 1'b1;
      if (chg && j == 2) begin
        wl_sel_i = 2'(wl) ^ 2'd1;
        append_i = ~app;
      end
    end
    req = chg ? "R10" : (app ? "R4" : "R3");
    chk(!bad, req, $sformatf("bit %0d", bad_j), got, want);
    chk(!fs_bad, "R2", "frame sync only on first bit", fs_bad, 0);
    wait_rise(per);
    chk(sfe_o && !sdo_oe_o && !sdo_o, "R5", "frame end after last bit",
        {sfe_o, sdo_oe_o, sdo_o}, 3'b100);
    wait_rise(per);
    chk(!sfe_o && !sdo_oe_o, "R6", "frame end single period, line released",
        {sfe_o, sdo_oe_o}, 0);
    found = 1'b0;
    for (int k = 0; k < 3; k++) begin
      wait_rise(per);
      if (fs_o || sdo_oe_o) found = 1'b1;
    end
    chk(!found, "R8", "no second frame without sample", found, 0);
    wl_sel_i = 2'(wl); append_i = app;
  endtask

  task automatic run_cascade(input int h, input int wl, input bit app,
                             input logic [23:0] iv, input logic [23:0] qv,
                             input logic [7:0] sv);
    int n, tot, bad_j;
    bit bad, fs_bad, got, want;
    master_i = 1'b0; wl_sel_i = 2'(wl); append_i = app;
    i_data_i = iv; q_data_i = qv; status_i = sv;
    sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    n = wlen(wl); tot = n * (app ? 3 : 2);
    bad = 1'b0; fs_bad = 1'b0; bad_j = 0; got = 0; want = 0;
    for (int p = 0; p <= tot + 2; p++) begin
      sclk_i = 1'b0; fs_i = (p == 1);
      repeat (h) @(negedge clk);
      sclk_i = 1'b1;
      repeat (h) @(negedge clk);
      if (fs_o || sclk_o) fs_bad = 1'b1;
      if (p == 0) begin
        chk(!sdo_oe_o && !sdo_o, "R9", "idle before strobe", {sdo_oe_o, sdo_o}, 0);
      end else if (p - 1 < tot) begin
        if (!bad && (!sdo_oe_o || sdo_o !== exp_bit(p - 1, n, iv, qv, sv))) begin
          bad = 1'b1; bad_j = p - 1; got = sdo_o;
          want = exp_bit(p - 1, n, iv, qv, sv);
        end
      end else if (p - 1 == tot) begin
        chk(sfe_o && !sdo_oe_o, "R5", "cascade frame end", {sfe_o, sdo_oe_o}, 2'b10);
      end else begin
        chk(!sfe_o, "R5", "cascade frame end single period", sfe_o, 0);
      end
    end
    chk(!bad, "R9", $sformatf("cascade bit %0d", bad_j), got, want);
    chk(!fs_bad, "R2", "no sync or clock driven in cascade", fs_bad, 0);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sample_valid_i = 1'b0; i_data_i = '0; q_data_i = '0;
    status_i = '0; master_i = 1'b1; div_i = 4'd1; wl_sel_i = 2'd0; append_i = 1'b0;
    sclk_i = 1'b0; fs_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(!sclk_o && !fs_o && !sfe_o && !sdo_o && !sdo_oe_o, "R11", "reset state",
        {sclk_o, fs_o, sfe_o, sdo_o, sdo_oe_o}, 0);
    rst_n = 1'b1;
    // directed corners
    run_master(0, 0, 1'b0, 24'hA5C3F0, 24'h5A3C0F, 8'h00, 1'b0);
    run_master(15, 3, 1'b1, 24'h800001, 24'h7FFFFE, 8'hC9, 1'b0);
    run_master(2, 1, 1'b0, 24'h123456, 24'hFEDCBA, 8'h11, 1'b1);
    // random frames
    for (int r = 0; r < 6; r++) begin
      run_master(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 24'($urandom), 24'($urandom),
                 8'($urandom), 1'b0);
    end
    run_cascade(4, 1, 1'b1, 24'hB0B1B2, 24'h0C0D0E, 8'h9A);
    run_cascade(5, 2, 1'b0, 24'($urandom), 24'($urandom), 8'h00);
    run_master(1, 2, 1'b1, 24'($urandom), 24'($urandom), 8'($urandom), 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule